// File: doc/BRIEF.md
# Packed SIMD Integer Unit

This unit executes one packed integer operation per strobe on two 128-bit operands. It supports lane-wise 64-bit addition and subtraction with wraparound, and a widening unsigned multiply that takes the even 32-bit elements of each operand and returns 64-bit products. It also provides two 16-bit word permutes under an 8-bit control byte, each acting on one 64-bit half, and a register-style move that checks a byte address for 16-byte alignment. A mode input selects full 128-bit operation or narrow 64-bit operation, in which only the low half carries a result.

Results are registered. A small two-state controller tracks whether the output register holds a fresh result. In **ST_IDLE**, a strobe takes the *accept* transition to **ST_HOLD**, and no strobe takes the *wait* transition back to ST_IDLE. In **ST_HOLD**, a strobe takes the *chain* transition and stays in ST_HOLD, and no strobe takes the *retire* transition to ST_IDLE. The valid output is high exactly in ST_HOLD. The fault and illegal flags are qualified by that valid output.

Opcode values are: 0 lane add (a+b), 1 lane subtract (a−b), 2 widening multiply (a×b), 3 low-half word permute of a, 4 high-half word permute of a, 5 aligned move of a, 6 unaligned move of a, 7 undefined.

Top module: `simd_exu`

## Requirements
- R1: After reset, `out_valid`, `fault`, `illegal` and `result` are all zero. `out_valid` is high in the cycle after each cycle in which `in_valid` is high, and low in the cycle after each cycle in which `in_valid` is low.
- R2: Opcode 0 adds `src_a` and `src_b` in each 64-bit lane independently. The carry out of a lane is dropped and never enters the next lane.
- R3: Opcode 1 subtracts `src_b` from `src_a` in each 64-bit lane independently. A borrow wraps within the lane and never reaches the next lane.
- R4: Opcode 2 multiplies `src_a[31:0]` by `src_b[31:0]` as unsigned values into `result[63:0]`. It also multiplies `src_a[95:64]` by `src_b[95:64]` as unsigned values into `result[127:64]`.
- R5: With `wide`=0, opcodes 0–2 act on lane 0 only, and `result[127:64]` is zero for every opcode.
- R6: Opcode 3 sets destination word i of `result[63:0]` (bits [16i+15:16i]) to word `imm[2i+1:2i]` of `src_a[63:0]`, so a source word may repeat. With `wide`=1, `result[127:64]` copies `src_a[127:64]`.
- R7: Opcode 4 sets destination word i of `result[127:64]` to word `imm[2i+1:2i]` of `src_a[127:64]`. `result[63:0]` copies `src_a[63:0]`.
- R8: Opcode 5 returns `src_a` when `addr[3:0]` is zero. If `addr[3:0]` is nonzero, it raises `fault` with a zero result.
- R9: Opcode 6 returns `src_a` for any address and never raises `fault`.
- R10: Opcode 7 returns a zero result and raises `illegal`. `fault` and `illegal` are never high together.
- R11: `result` keeps its value through any cycle without a strobe, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation strobe |
| opcode | input | 3 | Operation select (see encoding above) |
| wide | input | 1 | 1 = 128-bit operation, 0 = 64-bit operation |
| src_a | input | 128 | First operand |
| src_b | input | 128 | Second operand |
| imm | input | 8 | Word permute control, four 2-bit selectors |
| addr | input | 32 | Byte address checked by the aligned move |
| out_valid | output | 1 | Result valid, one cycle after the strobe |
| result | output | 128 | Registered result |
| fault | output | 1 | Misaligned address on aligned move |
| illegal | output | 1 | Undefined opcode |

## Verification
The bench checks lane isolation with an all-ones lane 0 plus one and a zero lane 0 minus one. A unit whose carry chain spans the full 128 bits would corrupt lane 1 in both cases. It multiplies all-ones 32-bit elements, with nonzero odd elements as decoys. That exposes a truncated product or a multiplier fed from elements 1 and 3. Permutes with repeated selectors and a nonzero untouched half reveal a swapped selector order, or a passive half that is zeroed instead of copied. Narrow-mode runs, misaligned and aligned addresses on both moves, back-to-back strobes and idle cycles catch a leaking upper half, a fault on the wrong move, and a result that drifts while idle.

// File: rtl/simd_pkg.sv
package simd_pkg;

    typedef enum logic [2:0] {
        OP_QADD = 3'd0,
        OP_QSUB = 3'd1,
        OP_WMUL = 3'd2,
        OP_SHLO = 3'd3,
        OP_SHHI = 3'd4,
        OP_MVAL = 3'd5,
        OP_MVUN = 3'd6,
        OP_UNDF = 3'd7
    } simd_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } exu_state_e;

endpackage

// File: rtl/simd_addsub.sv
module simd_addsub #(
    parameter int DATA_W = 128,
    parameter int LANE_W = 64
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              sub,
    output logic [DATA_W-1:0] y
);
    localparam int NLANES = DATA_W / LANE_W;

    // each lane has its own adder so no carry crosses a lane edge
    for (genvar l = 0; l < NLANES; l++) begin : g_lane
        logic [LANE_W-1:0] la, lb;
        assign la = a[l*LANE_W +: LANE_W];
        assign lb = b[l*LANE_W +: LANE_W];
        assign y[l*LANE_W +: LANE_W] = sub ? (la - lb) : (la + lb);
    end
endmodule

// File: rtl/simd_mulwide.sv
module simd_mulwide #(
    parameter int DATA_W = 128,
    parameter int LANE_W = 64
) (
    input  logic [DATA_W/2-1:0] a_even,
    input  logic [DATA_W/2-1:0] b_even,
    output logic [DATA_W-1:0]   y
);
    localparam int NLANES = DATA_W / LANE_W;
    localparam int HALF_W = LANE_W / 2;

    for (genvar l = 0; l < NLANES; l++) begin : g_mul
        logic [LANE_W-1:0] ea, eb;
        assign ea = LANE_W'(a_even[l*HALF_W +: HALF_W]);
        assign eb = LANE_W'(b_even[l*HALF_W +: HALF_W]);
        assign y[l*LANE_W +: LANE_W] = ea * eb;
    end
endmodule

// File: rtl/simd_shuffle.sv
module simd_shuffle #(
    parameter int DATA_W = 128,
    parameter int LANE_W = 64,
    parameter int WORD_W = 16,
    parameter int IMM_W  = 8
) (
    input  logic [DATA_W-1:0] src,
    input  logic [IMM_W-1:0]  ctl,
    input  logic              hi_sel,
    output logic [DATA_W-1:0] y
);
    localparam int NWORD = LANE_W / WORD_W;
    localparam int SEL_W = $clog2(NWORD);

    logic [LANE_W-1:0] half_in;
    logic [LANE_W-1:0] half_out;

    assign half_in = hi_sel ? src[DATA_W-1 -: LANE_W] : src[LANE_W-1:0];

    for (genvar i = 0; i < NWORD; i++) begin : g_word
        logic [SEL_W-1:0] pick;
        assign pick = ctl[i*SEL_W +: SEL_W];
        assign half_out[i*WORD_W +: WORD_W] = half_in[pick*WORD_W +: WORD_W];
    end

    // the half that is not permuted passes through untouched
    assign y = hi_sel ? {half_out, src[DATA_W-LANE_W-1:0]}
                      : {src[DATA_W-1:LANE_W], half_out};
endmodule

// File: rtl/simd_exu.sv
module simd_exu
    import simd_pkg::*;
#(
    parameter int DATA_W      = 128,
    parameter int LANE_W      = 64,
    parameter int WORD_W      = 16,
    parameter int ADDR_W      = 32,
    parameter int ALIGN_BYTES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [2:0]        opcode,
    input  logic              wide,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    input  logic [7:0]        imm,
    input  logic [ADDR_W-1:0] addr,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic              fault,
    output logic              illegal
);
    localparam int NLANES = DATA_W / LANE_W;
    localparam int HALF_W = LANE_W / 2;
    localparam int IMM_W  = 8;
    localparam logic [ADDR_W-1:0] ALIGN_MASK = ADDR_W'(ALIGN_BYTES - 1);

    simd_op_e   op_e;
    exu_state_e state_q, state_d;

    logic [DATA_W-1:0]   as_res, mul_res, shf_res;
    logic [DATA_W/2-1:0] a_even, b_even;
    logic [DATA_W-1:0]   res_d, res_q;
    logic                flt_d, flt_q, ill_d, ill_q;
    logic                misaligned;

    assign op_e       = simd_op_e'(opcode);
    assign misaligned = (addr & ALIGN_MASK) != '0;

    for (genvar l = 0; l < NLANES; l++) begin : g_even
        assign a_even[l*HALF_W +: HALF_W] = src_a[l*LANE_W +: HALF_W];
        assign b_even[l*HALF_W +: HALF_W] = src_b[l*LANE_W +: HALF_W];
    end

    simd_addsub #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_addsub (
        .a   (src_a),
        .b   (src_b),
        .sub (op_e == OP_QSUB),
        .y   (as_res)
    );

    simd_mulwide #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_mul (
        .a_even (a_even),
        .b_even (b_even),
        .y      (mul_res)
    );

    simd_shuffle #(.DATA_W(DATA_W), .LANE_W(LANE_W), .WORD_W(WORD_W), .IMM_W(IMM_W)) u_shf (
        .src    (src_a),
        .ctl    (imm),
        .hi_sel (op_e == OP_SHHI),
        .y      (shf_res)
    );

    // operation select
    always_comb begin
        res_d = '0;
        flt_d = 1'b0;
        ill_d = 1'b0;
        unique case (op_e)
            OP_QADD, OP_QSUB: res_d = as_res;
            OP_WMUL:          res_d = mul_res;
            OP_SHLO, OP_SHHI: res_d = shf_res;
            OP_MVAL: begin
                if (misaligned) flt_d = 1'b1;
                else            res_d = src_a;
            end
            OP_MVUN:          res_d = src_a;
            OP_UNDF:          ill_d = 1'b1;
        endcase
        if (!wide) res_d[DATA_W-1:LANE_W] = '0;
    end

    // controller: next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_HOLD : ST_IDLE;  // accept / wait
            ST_HOLD: state_d = in_valid ? ST_HOLD : ST_IDLE;  // chain / retire
        endcase
    end

    // controller: state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
            flt_q <= 1'b0;
            ill_q <= 1'b0;
        end else if (in_valid) begin
            res_q <= res_d;
            flt_q <= flt_d;
            ill_q <= ill_d;
        end
    end

    assign out_valid = (state_q == ST_HOLD);
    assign result    = res_q;
    assign fault     = out_valid & flt_q;
    assign illegal   = out_valid & ill_q;
endmodule

// File: rtl/simd_exu_chk.sv
module simd_exu_chk #(
    parameter int DATA_W      = 128,
    parameter int LANE_W      = 64,
    parameter int ADDR_W      = 32,
    parameter int ALIGN_BYTES = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [2:0]        opcode,
    input logic              wide,
    input logic [ADDR_W-1:0] addr,
    input logic              out_valid,
    input logic [DATA_W-1:0] result,
    input logic              fault,
    input logic              illegal
);
    localparam logic [ADDR_W-1:0] AMASK = ADDR_W'(ALIGN_BYTES - 1);

    // R1
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R1
    valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R11
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result));

    // R5
    narrow_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !wide) |=> (result[DATA_W-1:LANE_W] == '0));

    // R8
    misalign_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode == 3'd5 && (addr & AMASK) != '0) |=> (fault && result == '0));

    // R9
    unaligned_nofault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode == 3'd6) |=> !fault);

    // R10
    undef_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode == 3'd7) |=> (illegal && result == '0));

    // R10
    flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(fault && illegal));
endmodule

bind simd_exu simd_exu_chk #(
    .DATA_W(DATA_W), .LANE_W(LANE_W), .ADDR_W(ADDR_W), .ALIGN_BYTES(ALIGN_BYTES)
) u_chk (.*);

// File: tb/sim_simd_exu.sv
module sim_simd_exu;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [2:0]   opcode = '0;
    logic         wide = 1'b1;
    logic [127:0] src_a = '0, src_b = '0;
    logic [7:0]   imm = '0;
    logic [31:0]  addr = '0;
    logic         out_valid, fault, illegal;
    logic [127:0] result;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    simd_exu u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode), .wide(wide),
        .src_a(src_a), .src_b(src_b), .imm(imm), .addr(addr),
        .out_valid(out_valid), .result(result), .fault(fault), .illegal(illegal)
    );

    // behavioural model written from the requirements
    function automatic void model(input int op, input bit wd, input logic [127:0] a,
                                  input logic [127:0] b, input logic [7:0] im,
                                  input logic [31:0] ad, output logic [127:0] r,
                                  output bit f, output bit il);
        r = '0; f = 0; il = 0;
        case (op)
            0, 1, 2: for (int k = 0; k < 2; k++) begin
                logic [63:0] x, y;
                x = a[64*k +: 64]; y = b[64*k +: 64];
                if (op == 0)      r[64*k +: 64] = x + y;
                else if (op == 1) r[64*k +: 64] = x - y;
                else              r[64*k +: 64] = {32'd0, x[31:0]} * {32'd0, y[31:0]};
            end
            3: begin
                r = a;
                for (int i = 0; i < 4; i++) r[16*i +: 16] = a[16*int'(im[2*i +: 2]) +: 16];
            end
            4: begin
                r = a;
                for (int i = 0; i < 4; i++) r[64+16*i +: 16] = a[64+16*int'(im[2*i +: 2]) +: 16];
            end
            5: if (ad[3:0] != 0) f = 1; else r = a;
            6: r = a;
            default: il = 1;
        endcase
        if (!wd) r[127:64] = '0;
    endfunction

    function automatic string tag(input int op, input bit wd);
        if (!wd) return "R5";
        case (op)
            0: return "R2"; 1: return "R3"; 2: return "R4"; 3: return "R6";
            4: return "R7"; 5: return "R8"; 6: return "R9"; default: return "R10";
        endcase
    endfunction

    task automatic chk(input string req, input string what, input logic [127:0] got,
                       input logic [127:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    // drive at negedge, capture at posedge, sample at following negedge
    task automatic issue(input int op, input bit wd, input logic [127:0] a,
                         input logic [127:0] b, input logic [7:0] im, input logic [31:0] ad);
        opcode = 3'(op); wide = wd; src_a = a; src_b = b; imm = im; addr = ad;
        in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic run_check(input int op, input bit wd, input logic [127:0] a,
                             input logic [127:0] b, input logic [7:0] im, input logic [31:0] ad);
        logic [127:0] er; bit ef, ei; string t;
        model(op, wd, a, b, im, ad, er, ef, ei);
        t = tag(op, wd);
        issue(op, wd, a, b, im, ad);
        chk("R1", "out_valid", 128'(out_valid), 128'd1);
        chk(t, "result", result, er);
        chk(t, "fault", 128'(fault), 128'(ef));
        chk(t, "illegal", 128'(illegal), 128'(ei));
    endtask

    task automatic t_reset;
        chk("R1", "reset out_valid", 128'(out_valid), 128'd0);
        chk("R1", "reset result", result, '0);
        chk("R1", "reset flags", {126'd0, fault, illegal}, '0);
    endtask

    task automatic t_add;
        // R2: lane 0 all ones + 1 wraps to zero, lane 1 unaffected
        run_check(0, 1, {64'h5, 64'hFFFF_FFFF_FFFF_FFFF}, {64'h7, 64'h1}, 8'h0, 0);
        chk("R2", "lane carry", result, {64'hC, 64'h0});
        run_check(0, 1, {64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000},
                  {64'h2, 64'h8000_0000_0000_0000}, 8'h0, 0);
    endtask

    task automatic t_sub;
        // R3: lane 0 zero - 1 wraps to all ones, lane 1 keeps its value
        run_check(1, 1, {64'h10, 64'h0}, {64'h3, 64'h1}, 8'h0, 0);
        chk("R3", "lane borrow", result, {64'hD, 64'hFFFF_FFFF_FFFF_FFFF});
    endtask

    task automatic t_mul;
        // R4: maximum operands, odd elements as decoys
        run_check(2, 1, {32'h1234_5678, 32'hFFFF_FFFF, 32'hDEAD_BEEF, 32'hFFFF_FFFF},
                  {32'h9ABC_DEF0, 32'hFFFF_FFFF, 32'hCAFE_F00D, 32'hFFFF_FFFF}, 8'h0, 0);
        chk("R4", "max product", result, {64'hFFFF_FFFE_0000_0001, 64'hFFFF_FFFE_0000_0001});
        run_check(2, 1, {32'h0, 32'd3, 32'h0, 32'd7}, {32'h0, 32'd5, 32'h0, 32'd11}, 8'h0, 0);
    endtask

    task automatic t_shuffle;
        // R6: reverse order; R7: repeated selector (all pick word 2)
        run_check(3, 1, 128'h1111_2222_3333_4444_aaaa_bbbb_cccc_dddd, '0, 8'b00_01_10_11, 0);
        chk("R6", "reverse low", result, 128'h1111_2222_3333_4444_dddd_cccc_bbbb_aaaa);
        run_check(4, 1, 128'h1111_2222_3333_4444_aaaa_bbbb_cccc_dddd, '0, 8'b10_10_10_10, 0);
        chk("R7", "repeat high", result, 128'h2222_2222_2222_2222_aaaa_bbbb_cccc_dddd);
        run_check(3, 1, 128'h0123_4567_89ab_cdef_fedc_ba98_7654_3210, '0, 8'b11_00_10_01, 0);
    endtask

    task automatic t_move;
        run_check(5, 1, 128'hA5A5_0000_1111_2222_3333_4444_5555_6666, '0, 8'h0, 32'h0000_1000);
        run_check(5, 1, 128'hA5A5_0000_1111_2222_3333_4444_5555_6666, '0, 8'h0, 32'h0000_1008);
        chk("R8", "misaligned fault", {127'd0, fault}, 128'd1);
        run_check(6, 1, 128'h0F0F_0F0F_0F0F_0F0F_0F0F_0F0F_0F0F_0F0F, '0, 8'h0, 32'h0000_1003);
        chk("R9", "no fault", {127'd0, fault}, 128'd0);
    endtask

    task automatic t_narrow;
        for (int op = 0; op < 7; op++)
            run_check(op, 0, {64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_0000_0001},
                      {64'h1, 64'h0000_0001_FFFF_FFFF}, 8'h1B, 32'h40);
    endtask

    task automatic t_undefined;
        run_check(7, 1, 128'hDEAD, 128'hBEEF, 8'hFF, 0);
        chk("R10", "flags exclusive", 128'(fault & illegal), 128'd0);
    endtask

    task automatic t_hold;
        logic [127:0] kept;
        run_check(0, 1, {64'd1, 64'd2}, {64'd3, 64'd4}, 8'h0, 0);
        kept = result;
        opcode = 3'd7; src_a = '1; src_b = '1; wide = 1'b0;
        @(posedge clk); @(negedge clk);
        chk("R11", "result held", result, kept);
        chk("R1", "valid drops", 128'(out_valid), 128'd0);
    endtask

    task automatic t_back2back;
        opcode = 3'd0; wide = 1; src_a = {64'd10, 64'd20}; src_b = {64'd1, 64'd2};
        in_valid = 1;
        @(posedge clk); @(negedge clk);
        chk("R2", "first of pair", result, {64'd11, 64'd22});
        opcode = 3'd1;
        @(posedge clk); @(negedge clk);
        in_valid = 0;
        chk("R1", "second valid", 128'(out_valid), 128'd1);
        chk("R3", "second of pair", result, {64'd9, 64'd18});
    endtask

    task automatic t_random;
        for (int n = 0; n < 300; n++) begin
            logic [127:0] a, b; logic [31:0] ad;
            a = {$urandom, $urandom, $urandom, $urandom};
            b = {$urandom, $urandom, $urandom, $urandom};
            ad = $urandom;
            if (n % 2 == 0) ad[3:0] = 4'h0;
            run_check(int'($urandom % 8), bit'($urandom % 4 != 0), a, b, 8'($urandom), ad);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_add();
        t_sub();
        t_mul();
        t_shuffle();
        t_move();
        t_narrow();
        t_undefined();
        t_hold();
        t_back2back();
        t_random();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule